// File: doc/BRIEF.md
# Quadrature LO Divide-by-Four Generator

This block turns a clock running at four times the wanted local-oscillator frequency into two LO square waves: an in-phase wave and a quadrature wave that trails it by a quarter period, which is one input clock. The division is done by a two-stage twisted-ring (Johnson) counter. Both outputs therefore have an exact 50% duty cycle that does not depend on the shape of the input clock. The counter state then passes through a short chain of output flops, and the same 4x clock drives those flops, so every output edge lines up with a rising edge of that clock.

A synchronous, active-high reset clears the counter and the output flops. After reset is released, the first in-phase rising edge comes at a fixed, parameter-defined clock count. Any number of instances that see the same reset pulse on the same clock therefore run in lock-step, whatever state each one held beforehand. This is what keeps the LO phase coherent across a wide array of receive channels.

Top module: `quad_lo_div4`

## Requirements
- R1: Once running, `lo_i` is periodic with a period of exactly 4 `clk` cycles.
- R2: Each output is high for 2 consecutive cycles and then low for 2 consecutive cycles (50% duty cycle), and this does not change when the high time of `clk` varies within its period.
- R3: `lo_q` equals the value `lo_i` had one `clk` cycle earlier, which is a 90° lag.
- R4: A rising `clk` edge that samples `rst` high drives both `lo_i` and `lo_q` low, and they stay low for as long as `rst` is sampled high.
- R5: Number the rising edges that sample `rst` low from 1 after a release. `lo_i` first goes high after edge RETIME_DEPTH+1, and `lo_q` first goes high one edge later. Until then, both outputs are low.
- R6: Two instances on the same clock that get the same reset pulse produce identical `lo_i` and `lo_q` on every cycle after it, even if their states differed before the pulse.
- R7: Both outputs change only directly after a rising `clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input     | 1     | Input clock at four times the LO frequency |
| rst  | input     | 1     | Synchronous active-high reset; also acts as the phase-alignment pulse |
| lo_i | output    | 1     | In-phase LO square wave, clk/4 |
| lo_q | output    | 1     | Quadrature LO square wave, trailing `lo_i` by one clk cycle |

## Verification
A wrong counter state shows up at the ports within RETIME_DEPTH+1 cycles. Depending on the fault, it appears as a stuck output, a period other than four, a duty cycle other than two-high-two-low, or `lo_q` leading `lo_i` instead of trailing it. A reset that fails to clear the counter or any output flop breaks the fixed release-to-first-edge count. It also makes two jointly reset instances disagree on the very first cycles after the pulse. For this reason the outputs are compared against a cycle-exact model on every clock, and not only in steady state.

// File: rtl/qlo_pkg.sv
package qlo_pkg;

    // One sample of the quadrature pair; also the Johnson counter state.
    typedef struct packed {
        logic i;
        logic q;
    } qlo_pair_t;

    localparam qlo_pair_t QLO_IDLE = '{i: 1'b0, q: 1'b0};

    // Twisted-ring step: 00 -> 10 -> 11 -> 01 -> 00
    function automatic qlo_pair_t qlo_advance(input qlo_pair_t s);
        qlo_pair_t n;
        n.i = ~s.q;
        n.q = s.i;
        return n;
    endfunction

endpackage

// File: rtl/qlo_johnson_core.sv
module qlo_johnson_core
    import qlo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    output qlo_pair_t phase
);

    qlo_pair_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= QLO_IDLE;
        end else begin
            state <= qlo_advance(state);
        end
    end

    assign phase = state;

    // R4: reset clears the divider state on the next edge
    a_r4_core_cleared: assert property (@(posedge clk)
        rst |=> (state == QLO_IDLE));

    // R2: a twisted ring flips exactly one stage per cycle
    a_r2_one_flip: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(state ^ $past(state)) == 1));

endmodule

// File: rtl/qlo_retime.sv
module qlo_retime
    import qlo_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  qlo_pair_t din,
    output qlo_pair_t dout
);

    qlo_pair_t pipe [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= QLO_IDLE;
                    else     pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[g] <= QLO_IDLE;
                    else     pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[DEPTH-1];

    // R4: every output flop is cleared by reset
    a_r4_retime_cleared: assert property (@(posedge clk)
        rst |=> (dout == QLO_IDLE));

endmodule

// File: rtl/quad_lo_div4.sv
module quad_lo_div4
    import qlo_pkg::*;
#(
    parameter int RETIME_DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    output logic lo_i,
    output logic lo_q
);

    localparam int CNT_W   = $clog2(RETIME_DEPTH + 3) + 1;
    localparam int CNT_SAT = RETIME_DEPTH + 2;

    qlo_pair_t core_phase;
    qlo_pair_t out_phase;

    qlo_johnson_core u_core (
        .clk   (clk),
        .rst   (rst),
        .phase (core_phase)
    );

    qlo_retime #(.DEPTH(RETIME_DEPTH)) u_retime (
        .clk  (clk),
        .rst  (rst),
        .din  (core_phase),
        .dout (out_phase)
    );

    assign lo_i = out_phase.i;
    assign lo_q = out_phase.q;

    // Checker-side count of edges since reset release (saturating)
    logic [CNT_W-1:0] since_rel;
    always_ff @(posedge clk) begin
        if (rst)                                 since_rel <= '0;
        else if (since_rel != CNT_W'(CNT_SAT))   since_rel <= since_rel + 1'b1;
    end

    // R4: outputs low on the cycle after reset is sampled
    a_r4_outputs_low: assert property (@(posedge clk)
        rst |=> (!lo_i && !lo_q));

    // R5: nothing rises before the documented release latency
    a_r5_quiet_window: assert property (@(posedge clk) disable iff (rst)
        (since_rel <= CNT_W'(RETIME_DEPTH)) |-> (!lo_i && !lo_q));

    // R3: quadrature output trails in-phase by one cycle
    a_r3_q_lags_i: assert property (@(posedge clk) disable iff (rst)
        (since_rel >= CNT_W'(1)) |-> (lo_q == $past(lo_i)));

    // R1/R2: half a period later the in-phase output is inverted
    a_r1_half_period_flip: assert property (@(posedge clk) disable iff (rst)
        (since_rel > CNT_W'(RETIME_DEPTH)) |-> (lo_i == !$past(lo_i, 2)));

endmodule

// File: tb/sim_quad_lo_div4.sv
module sim_quad_lo_div4;

    localparam int D = 2;

    logic clk = 1'b0;
    logic rst_a, rst_b;
    logic i0, q0, i1, q1;

    int checks = 0;
    int fails  = 0;
    int na = 0, nb = 0;
    bit synced = 1'b0;
    bit done   = 1'b0;

    quad_lo_div4 #(.RETIME_DEPTH(D)) u0 (.clk(clk), .rst(rst_a), .lo_i(i0), .lo_q(q0));
    quad_lo_div4 #(.RETIME_DEPTH(D)) u1 (.clk(clk), .rst(rst_b), .lo_i(i1), .lo_q(q1));

    // 50 MHz, random high time each cycle (R2: duty of input must not matter)
    initial begin
        void'($urandom(32'd4242));
        forever begin
            int hi;
            hi = $urandom_range(16, 4);
            clk = 1'b1; #(hi);
            clk = 1'b0; #(20 - hi);
        end
    end

    // Edges since release, per instance
    always @(posedge clk) begin
        if (rst_a) na <= 0; else na <= na + 1;
        if (rst_b) nb <= 0; else nb <= nb + 1;
    end

    function automatic logic exp_i(input int n);
        int p;
        p = n - D;
        return (p > 0) && ((p % 4 == 1) || (p % 4 == 2));
    endfunction

    function automatic logic exp_q(input int n);
        int p;
        p = n - D;
        return (p > 0) && ((p % 4 == 2) || (p % 4 == 3));
    endfunction

    function automatic string tag_for(input int n);
        if (n == 0)       return "R4";
        if (n <= D + 2)   return "R5";
        return "R1";
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: sample at falling edge, compare, then drive resets
    task automatic cyc(input logic ra, input logic rb);
        logic s_i0, s_q0;
        @(negedge clk);
        check(i0 === exp_i(na), tag_for(na), int'(i0), int'(exp_i(na)));
        check(q0 === exp_q(na), tag_for(na), int'(q0), int'(exp_q(na)));
        check(i1 === exp_i(nb), tag_for(nb), int'(i1), int'(exp_i(nb)));
        check(q1 === exp_q(nb), tag_for(nb), int'(q1), int'(exp_q(nb)));
        if (synced) begin
            check({i0, q0} === {i1, q1}, "R6", int'({i1, q1}), int'({i0, q0}));
        end
        // R7: outputs hold until just before the next rising edge
        s_i0 = i0; s_q0 = q0;
        rst_a = ra; rst_b = rb;
        if (ra != rb) synced = 1'b0;
        #1;
        check({i0, q0} === {s_i0, s_q0}, "R7", int'({i0, q0}), int'({s_i0, s_q0}));
    endtask

    task automatic common_pulse(input int len);
        for (int k = 0; k < len; k++) cyc(1'b1, 1'b1);
        synced = 1'b1;
    endtask

    // Directed first-edge and waveform-shape checks on u0 (R5, R1, R2, R3)
    task automatic measure_after_pulse();
        logic si [16];
        logic sq [16];
        int first_i, first_q;
        first_i = -1; first_q = -1;
        common_pulse(2);
        cyc(1'b0, 1'b0);   // release driven; sampling starts next cycle
        for (int k = 1; k <= 16; k++) begin
            cyc(1'b0, 1'b0);
            si[k-1] = i0; sq[k-1] = q0;
            if (first_i < 0 && i0) first_i = k;
            if (first_q < 0 && q0) first_q = k;
        end
        check(first_i == D + 1, "R5", first_i, D + 1);
        check(first_q == D + 2, "R5", first_q, D + 2);
        for (int k = D + 1; k < 12; k++) begin
            check(si[k+4] === si[k], "R1", int'(si[k+4]), int'(si[k]));
            check(si[k+2] !== si[k], "R2", int'(si[k+2]), int'(!si[k]));
            check(sq[k+1] === si[k], "R3", int'(sq[k+1]), int'(si[k]));
        end
        begin
            int highs;
            highs = 0;
            for (int k = D + 1; k < D + 5; k++) highs += int'(si[k]);
            check(highs == 2, "R2", highs, 2);
            highs = 0;
            for (int k = D + 1; k < D + 5; k++) highs += int'(sq[k]);
            check(highs == 2, "R2", highs, 2);
        end
    endtask

    initial begin
        rst_a = 1'b1; rst_b = 1'b1;
        repeat (3) cyc(1'b1, 1'b1);
        // Desynchronise: release u0 first, u1 a few cycles later
        repeat (3) cyc(1'b0, 1'b1);
        repeat (10) cyc(1'b0, 1'b0);
        measure_after_pulse();
        // Long reset holds outputs low (R4)
        for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0);
        // Random mix of private and shared pulses
        for (int it = 0; it < 60; it++) begin
            int mode, len, run;
            mode = $urandom_range(2, 0);
            len  = $urandom_range(3, 1);
            run  = $urandom_range(20, 1);
            if (mode == 0) begin
                for (int k = 0; k < len; k++) cyc(1'b1, 1'b0);
            end else if (mode == 1) begin
                for (int k = 0; k < len; k++) cyc(1'b0, 1'b1);
            end else begin
                common_pulse(len);
            end
            for (int k = 0; k < run; k++) cyc(1'b0, 1'b0);
        end
        common_pulse(1);
        for (int k = 0; k < 24; k++) cyc(1'b0, 1'b0);
        measure_after_pulse();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule